// File: doc/BRIEF.md
# Character LCD Nibble Writer over an I2C Port Expander

This block accepts one 8-bit byte for an HD44780-style character display, together with a register-select bit that marks it as a command or as character data. It delivers that byte to a display running in 4-bit mode. The display is reached through an 8-bit I2C port expander, and each expander pin drives one LCD control or data line. The block never drives I2C wires itself. It sequences a separate frame engine one frame at a time. For every frame it presents the byte to send and flags that ask for a START before the frame or a STOP after it. It then waits until the engine reports that the frame is finished.

Each LCD byte becomes a five-frame transaction. The first frame is the expander's address with the write bit. Two frames then place the high nibble, first with the enable line high and then with it low, so the falling edge latches that nibble. Two more frames do the same for the low nibble. The expander pins map as follows: bit 7 to bit 4 carry the nibble, bit 3 is the backlight, bit 2 is enable, bit 1 is read/write, and bit 0 is register select. When the fifth frame has finished, the block pulses `done` and is ready for the next byte.

Top module: `lcd_nibble_writer`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `frm_go` are 0 until a request arrives.
- R2: The first frame of a transaction has `frm_byte` = {SLAVE_ADDR (default 7'h27), 1'b0} = 8'h4E. It has `frm_first` = 1 and `frm_last` = 0.
- R3: Frames 2 and 3 carry the high nibble of the captured byte in bits 7:4. The enable bit (bit 2) is 1 in frame 2 and 0 in frame 3.
- R4: Frames 4 and 5 carry the low nibble of the captured byte in bits 7:4. The enable bit (bit 2) is 1 in frame 4 and 0 in frame 5.
- R5: `frm_first` is 1 only on frame 1. `frm_last` is 1 only on frame 5.
- R6: In frames 2 to 5, bit 0 equals the captured register-select value, bit 1 (read/write) is 0, and bit 3 (backlight) is 1.
- R7: `frm_go` is a one-cycle pulse. The next frame is issued in the cycle after `frm_done` is seen. Exactly five frames are issued per request.
- R8: `done` is high for exactly one cycle, in the cycle after `frm_done` of frame 5. In that cycle `busy` is already 0.
- R9: A `req_go` that arrives while `busy` is 1 is ignored. The later frames still carry the byte and register-select value captured at the start.
- R10: A `req_go` in the same cycle that `done` is high is accepted, and its first frame is issued in the next cycle.
- R11: `frm_byte` and `frm_last` hold steady from a frame's `frm_go` until its `frm_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_go | input | 1 | Start strobe for a new LCD byte |
| req_byte | input | 8 | LCD command or character byte |
| req_rs | input | 1 | Register select: 0 command, 1 data |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse when the transaction has finished |
| frm_go | output | 1 | One-cycle request to the frame engine to send a frame |
| frm_byte | output | 8 | Byte for the current frame |
| frm_first | output | 1 | Current frame is preceded by START |
| frm_last | output | 1 | Current frame is followed by STOP |
| frm_done | input | 1 | Frame engine has finished the current frame |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. A request that arrives while `done` is high must be captured, not dropped or delayed. The bench runs all 512 pairs of byte and register-select value back to back, raising the next `req_go` in the very cycle where `done` is seen. It judges the result by the address frame appearing on the following cycle and by every later frame carrying the new byte. A second pairing, a stray request during the wait for frame 2, is injected on many transactions, and the bench checks that it leaves the captured byte unchanged.

// File: rtl/lcdx_pkg.sv
package lcdx_pkg;
  localparam int unsigned FRAME_CNT = 5;
  localparam int unsigned IDX_W     = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_t;

  // pins of the expander: nibble | backlight | enable | read/write | reg-select
  function automatic logic [7:0] expander_byte(input logic [3:0] nib,
                                               input logic       bl,
                                               input logic       en,
                                               input logic       rs);
    return {nib, bl, en, 1'b0, rs};
  endfunction

  function automatic logic [7:0] addr_byte(input logic [6:0] addr);
    return {addr, 1'b0};
  endfunction

  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic hi);
    return hi ? b[7:4] : b[3:0];
  endfunction
endpackage

// File: rtl/lcdx_req_hold.sv
module lcdx_req_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              rs_in,
  output logic [DATA_W-1:0] byte_q,
  output logic              rs_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      rs_q   <= 1'b0;
    end else if (take) begin
      byte_q <= byte_in;
      rs_q   <= rs_in;
    end
  end
endmodule

// File: rtl/lcdx_frame_seq.sv
module lcdx_frame_seq
  import lcdx_pkg::*;
#(
  parameter int unsigned NFRAMES = FRAME_CNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             frm_done,
  output logic             take,
  output logic             busy,
  output logic             frm_go,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NFRAMES - 1);

  seq_state_t state;
  logic       last_done;

  assign take      = go_req && (state == SQ_IDLE);
  assign busy      = (state != SQ_IDLE);
  assign frm_go    = (state == SQ_ISSUE);
  assign last_done = (state == SQ_WAIT) && frm_done && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_done;
      unique case (state)
        SQ_IDLE: if (take) begin
          state <= SQ_ISSUE;
          idx   <= '0;
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: if (frm_done) begin
          if (idx == LAST_IDX) begin
            state <= SQ_IDLE;
          end else begin
            state <= SQ_ISSUE;
            idx   <= idx + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcdx_frame_mux.sv
module lcdx_frame_mux
  import lcdx_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h27,
  parameter logic        BL_ON      = 1'b1,
  parameter int unsigned NFRAMES    = FRAME_CNT
) (
  input  logic [7:0]       byte_q,
  input  logic             rs_q,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       frm_byte,
  output logic             frm_first,
  output logic             frm_last
);
  logic [7:0] tbl [NFRAMES];

  for (genvar k = 0; k < NFRAMES; k++) begin : g_frame
    if (k == 0) begin : g_addr
      assign tbl[k] = addr_byte(SLAVE_ADDR);
    end else begin : g_data
      localparam logic EN_LVL = ((k % 2) == 1);
      localparam logic HI_NIB = (k < 3);
      assign tbl[k] = expander_byte(pick_nibble(byte_q, HI_NIB), BL_ON, EN_LVL, rs_q);
    end
  end

  always_comb begin
    frm_byte = '0;
    for (int j = 0; j < NFRAMES; j++) begin
      if (idx == IDX_W'(j)) frm_byte = tbl[j];
    end
  end

  assign frm_first = (idx == '0);
  assign frm_last  = (idx == IDX_W'(NFRAMES - 1));
endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer
  import lcdx_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h27,
  parameter logic       BL_ON      = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_go,
  input  logic [7:0] req_byte,
  input  logic       req_rs,
  output logic       busy,
  output logic       done,
  output logic       frm_go,
  output logic [7:0] frm_byte,
  output logic       frm_first,
  output logic       frm_last,
  input  logic       frm_done
);
  logic             take;
  logic [7:0]       byte_q;
  logic             rs_q;
  logic [IDX_W-1:0] idx;

  lcdx_req_hold #(.DATA_W(8)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .byte_in (req_byte),
    .rs_in   (req_rs),
    .byte_q  (byte_q),
    .rs_q    (rs_q)
  );

  lcdx_frame_seq #(.NFRAMES(FRAME_CNT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_req   (req_go),
    .frm_done (frm_done),
    .take     (take),
    .busy     (busy),
    .frm_go   (frm_go),
    .done     (done),
    .idx      (idx)
  );

  lcdx_frame_mux #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .BL_ON      (BL_ON),
    .NFRAMES    (FRAME_CNT)
  ) u_mux (
    .byte_q    (byte_q),
    .rs_q      (rs_q),
    .idx       (idx),
    .frm_byte  (frm_byte),
    .frm_first (frm_first),
    .frm_last  (frm_last)
  );
endmodule

// File: rtl/lcdx_chk.sv
module lcdx_chk #(
  parameter logic [6:0] SLAVE_ADDR = 7'h27
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       frm_go,
  input logic [7:0] frm_byte,
  input logic       frm_first,
  input logic       frm_last,
  input logic       frm_done
);
  // R7
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_go |=> !frm_go);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(frm_done));

  // R2
  addr_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_go && frm_first) |-> (frm_byte == {SLAVE_ADDR, 1'b0}));

  // R5
  first_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_go |-> !(frm_first && frm_last));

  // R6
  data_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_go && !frm_first) |-> (frm_byte[3] && !frm_byte[1]));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frm_done) |=> ($stable(frm_byte) && $stable(frm_last)));
endmodule

bind lcd_nibble_writer lcdx_chk #(.SLAVE_ADDR(SLAVE_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .frm_go    (frm_go),
  .frm_byte  (frm_byte),
  .frm_first (frm_first),
  .frm_last  (frm_last),
  .frm_done  (frm_done)
);

// File: tb/test_lcd_nibble_writer.sv
module test_lcd_nibble_writer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_go = 1'b0;
  logic [7:0] req_byte = '0;
  logic       req_rs = 1'b0;
  logic       frm_done = 1'b0;
  logic       busy, done, frm_go, frm_first, frm_last;
  logic [7:0] frm_byte;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_nibble_writer i_lcd_nibble_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_go    (req_go),
    .req_byte  (req_byte),
    .req_rs    (req_rs),
    .busy      (busy),
    .done      (done),
    .frm_go    (frm_go),
    .frm_byte  (frm_byte),
    .frm_first (frm_first),
    .frm_last  (frm_last),
    .frm_done  (frm_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // arithmetic restatement of the expander byte for frame k (0..4)
  function automatic int expect_frame(input int b, input int rs, input int k);
    int nib;
    int en;
    if (k == 0) return 'h27 * 2;
    nib = (k < 3) ? (b / 16) : (b % 16);
    en  = k % 2;
    return nib * 16 + 8 + en * 4 + rs;
  endfunction

  task automatic run_txn(input int b, input int rs, input int lat, input bit stray);
    req_go = 1'b1; req_byte = b[7:0]; req_rs = rs[0];
    @(negedge clk);
    req_go = 1'b0;
    // R10: done from any earlier transaction has fallen
    chk(!done, "R10 done cleared", int'(done), 0);
    for (int k = 0; k < 5; k++) begin
      chk(frm_go, "R7 go issued", int'(frm_go), 1);
      if (k == 0) chk(int'(frm_byte) == expect_frame(b, rs, 0), "R2 address frame",
                      int'(frm_byte), expect_frame(b, rs, 0));
      else if (k < 3) chk(int'(frm_byte) == expect_frame(b, rs, k), "R3 high nibble frame",
                          int'(frm_byte), expect_frame(b, rs, k));
      else chk(int'(frm_byte) == expect_frame(b, rs, k), "R4 low nibble frame",
               int'(frm_byte), expect_frame(b, rs, k));
      if (k > 0) chk(int'(frm_byte[0]) == rs && !frm_byte[1] && frm_byte[3],
                     "R6 rs rw backlight", int'(frm_byte[3:0]), rs + 8);
      chk(frm_first == (k == 0), "R5 first flag", int'(frm_first), int'(k == 0));
      chk(frm_last == (k == 4), "R5 last flag", int'(frm_last), int'(k == 4));
      @(negedge clk);
      for (int j = 0; j < lat; j++) begin
        chk(!frm_go, "R7 no reissue while waiting", int'(frm_go), 0);
        chk(int'(frm_byte) == expect_frame(b, rs, k), "R11 byte held",
            int'(frm_byte), expect_frame(b, rs, k));
        chk(busy && !done, "R8 busy during frame", int'({busy, done}), 2);
        if (stray && k == 1 && j == 0) begin
          // R9: stray request while busy
          req_go = 1'b1; req_byte = ~b[7:0]; req_rs = ~rs[0];
        end
        @(negedge clk);
        req_go = 1'b0;
      end
      frm_done = 1'b1;
      @(negedge clk);
      frm_done = 1'b0;
    end
    chk(done, "R8 done pulse", int'(done), 1);
    chk(!busy, "R8 idle at done", int'(busy), 0);
    chk(!frm_go, "R7 five frames only", int'(frm_go), 0);
  endtask

  initial begin
    // R1
    @(negedge clk);
    chk(!busy && !done && !frm_go, "R1 reset state", int'({busy, done, frm_go}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !frm_go, "R1 after reset", int'({busy, done, frm_go}), 0);
    for (int i = 0; i < 512; i++) begin
      // R9 stray strobes exercised on every third transaction
      run_txn(i % 256, i / 256, 1 + (i % 4), (i % 3) == 0);
      if ((i % 7) == 0) begin
        @(negedge clk);
        chk(!done && !busy && !frm_go, "R8 done single cycle", int'({busy, done, frm_go}), 0);
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R8 final idle", int'({busy, done}), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule